// File: doc/BRIEF.md
# Dual Output Compare Match Unit

This block watches an 8-bit timer count and compares it with two programmable compare values, channel A (index 0) and channel B (index 1). Each channel gives a match pulse to a downstream waveform generator, plus a sticky match flag and an interrupt request. The waveform generator and the decoding of its output modes belong to other blocks.

A match does not set its flag at once. A match seen on one timer tick is held as pending, and the flag goes up on the following timer tick. The flag then stays set until one of two things happens: the interrupt controller acknowledges that channel's interrupt, or software writes a one to that channel's flag bit. The timer tick is an enable input on the system clock. While it is low, the timer is stopped and no flag can become set.

Top module: `ocmp_dual`

## Requirements
- R1: After a synchronous reset, both compare values, the pending matches, the match pulses, the flags and the interrupt requests are all zero.
- R2: A cycle with `cmp_wr[i]` high loads `cmp_wdata` into channel i's compare value (bit 0 is A, bit 1 is B). Later matches use the new value.
- R3: `match_o[i]` is high in the cycle after a cycle in which `count` equals channel i's compare value. This is evaluated on every clock, whether or not `tick` is high.
- R4: A cycle with `tick` high records in channel i's pending match whether `count` equals the compare value. If that pending match is one at the next cycle with `tick` high, `flag_o[i]` is high from the following cycle.
- R5: While `tick` is low, no flag becomes set and the pending match is kept as it is.
- R6: `irq_o[i]` is high in the cycle after a cycle in which the next-state flag of channel i is one and `irq_en[i]` is high.
- R7: A high `irq_ack[i]` clears `flag_o[i]` from the next cycle.
- R8: A cycle with `flag_clr_wr` high clears every flag whose bit in `flag_clr_data` is one. A flag whose bit is zero keeps its value.
- R9: If a set and a clear for the same channel arrive in the same cycle, the set wins and the flag is one.
- R10: The two channels are independent. A write, an acknowledge or a clear for one channel does not change the other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer clock enable |
| count | input | 8 | Current timer count |
| cmp_wr | input | 2 | Compare value write strobe, one bit per channel |
| cmp_wdata | input | 8 | Compare value write data |
| irq_en | input | 2 | Interrupt enable per channel |
| irq_ack | input | 2 | Interrupt acknowledge strobe per channel |
| flag_clr_wr | input | 1 | Flag clear write strobe |
| flag_clr_data | input | 2 | Flag clear data; a one clears that channel's flag |
| match_o | output | 2 | Registered match pulse per channel |
| flag_o | output | 2 | Match flag per channel |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
The bench targets the one-tick delay between a match and its flag, and it stops the timer between the two ticks. A design that sets the flag right away would raise it one tick early. A design that drops the pending match while the timer is stopped would never raise it at all. The bench also sets a flag and clears it in the same cycle: a design that lets the clear win would lose an interrupt. It writes a zero to a flag bit to catch a design that clears flags blindly. Random traffic with a small count range makes matches, acknowledges and writes collide on both channels, so any leakage from one channel into the other shows up.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

  localparam int CNT_W_DEF = 8;
  localparam int NCH_DEF   = 2;

  // One cycle's worth of flag events for a single channel.
  typedef struct packed {
    logic set;
    logic clr;
  } flag_ev_t;

endpackage

// File: rtl/ocmp_chan_cmp.sv
module ocmp_chan_cmp #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic             match_o,
  output logic             pend_o
);

  logic [CNT_W-1:0] cmp_q;
  logic             match_q;
  logic             pend_q;
  logic             eq;

  assign eq = (count == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      match_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr)
        cmp_q <= wdata;
      match_q <= eq;
      if (tick)
        pend_q <= eq;
    end
  end

  assign match_o = match_q;
  assign pend_o  = pend_q;

  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr |=> (cmp_q == $past(wdata))); // R2

  AST_PEND_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pend_q)); // R5

endmodule

// File: rtl/ocmp_chan_flag.sv
module ocmp_chan_flag
  import ocmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pend,
  input  logic ack,
  input  logic sw_clr,
  input  logic irq_en,
  output logic flag_o,
  output logic irq_o
);

  flag_ev_t ev;
  logic     flag_q;
  logic     irq_q;
  logic     flag_d;

  always_comb begin
    ev.set = tick & pend;
    ev.clr = ack | sw_clr;
    // A set outranks a clear that arrives in the same cycle.
    flag_d = ev.set | (flag_q & ~ev.clr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (tick && pend) |=> flag_q); // R9

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
    ((ack || sw_clr) && !(tick && pend)) |=> !flag_q); // R7

  AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!tick && !flag_q) |=> !flag_q); // R5

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!(tick && pend) && !ack && !sw_clr) |=> (flag_q == $past(flag_q))); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q); // R6

endmodule

// File: rtl/ocmp_dual.sv
module ocmp_dual #(
  parameter int CNT_W = ocmp_pkg::CNT_W_DEF,
  parameter int NCH   = ocmp_pkg::NCH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic [NCH-1:0]   cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [NCH-1:0]   irq_en,
  input  logic [NCH-1:0]   irq_ack,
  input  logic             flag_clr_wr,
  input  logic [NCH-1:0]   flag_clr_data,
  output logic [NCH-1:0]   match_o,
  output logic [NCH-1:0]   flag_o,
  output logic [NCH-1:0]   irq_o
);

  logic [NCH-1:0] pend;
  logic [NCH-1:0] sw_clr;

  assign sw_clr = flag_clr_data & {NCH{flag_clr_wr}};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    ocmp_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .count   (count),
      .wr      (cmp_wr[ch]),
      .wdata   (cmp_wdata),
      .match_o (match_o[ch]),
      .pend_o  (pend[ch])
    );

    ocmp_chan_flag u_flag (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .pend   (pend[ch]),
      .ack    (irq_ack[ch]),
      .sw_clr (sw_clr[ch]),
      .irq_en (irq_en[ch]),
      .flag_o (flag_o[ch]),
      .irq_o  (irq_o[ch])
    );

    AST_FLAG_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
      (!flag_o[ch] ##1 flag_o[ch]) |-> $past(tick && pend[ch])); // R4
  end

endmodule

// File: tb/ocmp_dual_test.sv
module ocmp_dual_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [7:0] count = '0;
  logic [1:0] cmp_wr = '0;
  logic [7:0] cmp_wdata = '0;
  logic [1:0] irq_en = '0;
  logic [1:0] irq_ack = '0;
  logic       clr_wr = 1'b0;
  logic [1:0] clr_data = '0;
  logic [1:0] match_o, flag_o, irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [7:0] m_cmp [2];
  bit m_pend [2];
  bit m_flag [2];
  bit m_irq [2];
  bit m_match [2];

  always #(CLK_P/2) clk = ~clk;

  ocmp_dual uut (
    .clk(clk), .rst(rst), .tick(tick), .count(count),
    .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .irq_en(irq_en),
    .irq_ack(irq_ack), .flag_clr_wr(clr_wr), .flag_clr_data(clr_data),
    .match_o(match_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        m_cmp[i] = '0; m_pend[i] = 0; m_flag[i] = 0; m_irq[i] = 0; m_match[i] = 0;
      end else begin
        bit eq = (count == m_cmp[i]);
        bit nf = m_flag[i];
        if (irq_ack[i] || (clr_wr && clr_data[i])) nf = 0;
        if (tick && m_pend[i]) nf = 1;
        m_flag[i]  = nf;
        m_irq[i]   = nf && irq_en[i];
        m_match[i] = eq;
        if (tick) m_pend[i] = eq;
        if (cmp_wr[i]) m_cmp[i] = cmp_wdata;
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R3 match", match_o, {m_match[1], m_match[0]});
    chk("R4/R7/R8/R9 flag", flag_o, {m_flag[1], m_flag[0]});
    chk("R6 irq", irq_o, {m_irq[1], m_irq[0]});
  endtask

  task automatic idle_strobes();
    cmp_wr = '0; irq_ack = '0; clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    repeat (3) step();
    // R1: everything cleared by reset
    chk("R1 match", match_o, 2'b00);
    chk("R1 flag", flag_o, 2'b00);
    chk("R1 irq", irq_o, 2'b00);
    rst = 1'b0;
    irq_en = 2'b11;

    // R2: load A=5, B=9
    cmp_wr = 2'b01; cmp_wdata = 8'd5; step();
    cmp_wr = 2'b10; cmp_wdata = 8'd9; step();
    idle_strobes();

    // Count upward with the timer running
    tick = 1'b1;
    for (int c = 0; c < 16; c++) begin
      count = 8'(c);
      step();
    end
    chk("R10 both flags", flag_o, 2'b11);
    chk("R6 both irqs", irq_o, 2'b11);

    // R8: clear A by software, B untouched
    tick = 1'b0;
    clr_wr = 1'b1; clr_data = 2'b01; step();
    chk("R8 clear A", flag_o, 2'b10);
    clr_data = 2'b00; step();
    chk("R8 zero write", flag_o, 2'b10);
    idle_strobes();

    // R7: acknowledge B
    irq_ack = 2'b10; step();
    idle_strobes();
    chk("R7 ack B", flag_o, 2'b00);
    chk("R6 irq low", irq_o, 2'b00);

    // R5/R4: pending match held across a stopped timer
    count = 8'd5; tick = 1'b1; step();
    tick = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R5 no set while stopped", flag_o, 2'b00);
      chk("R3 match without tick", match_o, 2'b01);
    end
    count = 8'd0; tick = 1'b1; step();
    chk("R4 set on next tick", flag_o, 2'b01);
    tick = 1'b0; irq_ack = 2'b01; step();
    idle_strobes();
    chk("R7 ack A", flag_o, 2'b00);

    // R9: set and clear collide on B
    count = 8'd9; tick = 1'b1; step();
    count = 8'd0; clr_wr = 1'b1; clr_data = 2'b10; irq_ack = 2'b10; step();
    idle_strobes();
    chk("R9 set wins", flag_o, 2'b10);
    tick = 1'b0; irq_ack = 2'b10; step();
    idle_strobes();

    // R2: new value used by later compares
    cmp_wr = 2'b01; cmp_wdata = 8'h80; step();
    idle_strobes();
    count = 8'h80; step();
    chk("R2 new compare value", match_o, 2'b01);

    // Mixed random traffic, model compared every cycle (R10)
    for (int n = 0; n < 500; n++) begin
      tick     = ($urandom_range(0, 3) != 0);
      count    = 8'($urandom_range(0, 15));
      cmp_wr   = ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      cmp_wdata = 8'($urandom_range(0, 15));
      irq_en   = 2'($urandom_range(0, 3));
      irq_ack  = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      clr_wr   = ($urandom_range(0, 5) == 0);
      clr_data = 2'($urandom_range(0, 3));
      step();
    end
    idle_strobes();
    tick = 1'b0;
    step();

    done = 1'b1;
    summary();
    $finish;
  end

endmodule